// File: doc/BRIEF.md
# Logarithmic Barrel Shifter

A purely combinational shifter for a word of `WIDTH` bits, where `WIDTH` is a power of two and defaults to 32. The shift count is `$clog2(WIDTH)` bits wide. A chain of multiplexer stages performs the shift. Stage `s` moves the word by `2**s` positions when bit `s` of the count is set. When that bit is clear, the stage passes the word through unchanged.

The block has only one left-moving stage chain. For a right shift, it mirrors the bit order of the word on the way into the chain and mirrors it again on the way out. Arithmetic and logical right shifts use the same datapath. They differ only in the bit that enters the vacated positions: the original top bit for arithmetic, zero for logical.

Two control styles are available, and `use_opcode` picks between them. One style is a 3-bit operation code. The other is a pair of pins that give direction and fill mode. When `enable` is low, or when the operation code is not recognised, the output is all zeros.

Top module: `log_shifter`

## Requirements
- R1: A left shift gives `data_in << amount`. The `amount` input is `$clog2(WIDTH)` bits wide, and the vacated low-order bits are always 0.
- R2: A logical right shift gives `data_in >> amount`, with zeros entering at the top.
- R3: An arithmetic right shift gives `data_in` shifted right by `amount`. Every vacated top position is filled with copies of the original bit `WIDTH-1`.
- R4: When the block is enabled with a recognised operation and `amount` is 0, `data_out` equals `data_in`.
- R5: When `enable` is 0, `data_out` is all zeros, whatever the other inputs are.
- R6: When `use_opcode` is 1, the operation code selects the shift. Code 3'b100 is a left shift. Code 3'b101 is an arithmetic right shift. Every other code produces all zeros.
- R7: When `use_opcode` is 0, the pins select the shift. `dir_left`=1 selects a left shift. Otherwise `fill_logical`=1 selects a logical right shift and 0 selects an arithmetic right shift. A left shift with `fill_logical`=0 gives the same result as a logical left shift.
- R8: The shift distance is the sum of the powers of two whose count bits are set. For example, `amount`=5 moves a 32-bit word by exactly 5 positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| enable | input | 1 | When 0, the output is forced to zero |
| use_opcode | input | 1 | 1: `opcode` controls the shift; 0: `dir_left`/`fill_logical` control it |
| opcode | input | 3 | Operation code (3'b100 left, 3'b101 arithmetic right) |
| dir_left | input | 1 | Pin control: 1 = left shift, 0 = right shift |
| fill_logical | input | 1 | Pin control: 1 = zero fill, 0 = sign fill on right shifts |
| amount | input | $clog2(WIDTH) | Shift distance |
| data_in | input | WIDTH | Word to shift |
| data_out | output | WIDTH | Shifted word |

## Verification
Every result of this block is combinational, so each result is due in the same cycle as its stimulus, zero clock edges later. The bench changes the inputs and waits for the next falling clock edge before it compares `data_out`, so the mux chain has settled by the time each sample is taken. An 8-bit copy is swept over every data word and every count for all three shifts. The 32-bit instance is swept over every count and every control combination, using random and edge-case words, and its results are compared against `<<`, `>>` and `>>>` computed in the bench.

// File: rtl/shifter_pkg.sv
package shifter_pkg;

    typedef enum logic [1:0] {
        SH_NONE      = 2'd0,
        SH_LEFT      = 2'd1,
        SH_RIGHT_LOG = 2'd2,
        SH_RIGHT_ARI = 2'd3
    } shift_kind_e;

    typedef struct packed {
        logic active;     // produce a shifted result
        logic mirror;     // right shift: reverse bit order around the tree
        logic sign_fill;  // fill vacated bits with original MSB
    } shift_ctl_t;

    localparam logic [2:0] OPC_SHL = 3'b100;
    localparam logic [2:0] OPC_SAR = 3'b101;

    function automatic shift_ctl_t kind_to_ctl(shift_kind_e k);
        shift_ctl_t c;
        c = '0;
        case (k)
            SH_LEFT:      c = '{active: 1'b1, mirror: 1'b0, sign_fill: 1'b0};
            SH_RIGHT_LOG: c = '{active: 1'b1, mirror: 1'b1, sign_fill: 1'b0};
            SH_RIGHT_ARI: c = '{active: 1'b1, mirror: 1'b1, sign_fill: 1'b1};
            default:      c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/shift_decode.sv
module shift_decode
    import shifter_pkg::*;
(
    input  logic       enable,
    input  logic       use_opcode,
    input  logic [2:0] opcode,
    input  logic       dir_left,
    input  logic       fill_logical,
    output shift_kind_e kind,
    output shift_ctl_t  ctl
);

    always_comb begin
        kind = SH_NONE;
        if (enable) begin
            if (use_opcode) begin
                case (opcode)
                    OPC_SHL: kind = SH_LEFT;
                    OPC_SAR: kind = SH_RIGHT_ARI;
                    default: kind = SH_NONE;
                endcase
            end else if (dir_left) begin
                kind = SH_LEFT;           // fill mode is irrelevant to the left shift
            end else begin
                kind = fill_logical ? SH_RIGHT_LOG : SH_RIGHT_ARI;
            end
        end
        ctl = kind_to_ctl(kind);
    end

    // R6: an unrecognised opcode in opcode mode never yields an active shift
    always_comb begin
        if (enable && use_opcode && opcode != OPC_SHL && opcode != OPC_SAR)
            p_bad_opcode_idle_r6: assert (!ctl.active)
                else $error("unknown opcode produced an active shift");
    end

endmodule

// File: rtl/bit_mirror.sv
module bit_mirror #(
    parameter int W = 32
) (
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign dout[i] = din[W-1-i];
    end

endmodule

// File: rtl/shift_tree.sv
module shift_tree #(
    parameter int W  = 32,
    parameter int AW = $clog2(W)
) (
    input  logic [W-1:0]  din,
    input  logic [AW-1:0] amt,
    input  logic          fill,
    output logic [W-1:0]  dout
);

    logic [W-1:0] stage [0:AW];

    assign stage[0] = din;

    for (genvar s = 0; s < AW; s++) begin : g_stage
        localparam int STEP = 1 << s;
        assign stage[s+1] = amt[s] ? {stage[s][W-1-STEP:0], {STEP{fill}}} : stage[s];
    end

    assign dout = stage[AW];

    // R8: after any nonzero distance the lowest bit carries the fill value
    always_comb begin
        if (amt != '0)
            p_low_bit_filled_r8: assert (dout[0] == fill)
                else $error("lowest bit does not hold fill after a shift");
    end

endmodule

// File: rtl/log_shifter.sv
module log_shifter
    import shifter_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic                       enable,
    input  logic                       use_opcode,
    input  logic [2:0]                 opcode,
    input  logic                       dir_left,
    input  logic                       fill_logical,
    input  logic [$clog2(WIDTH)-1:0]   amount,
    input  logic [WIDTH-1:0]           data_in,
    output logic [WIDTH-1:0]           data_out
);

    localparam int AMT_W = $clog2(WIDTH);

    initial begin
        p_width_pow2_r1: assert ((1 << AMT_W) == WIDTH && WIDTH >= 2)
            else $error("WIDTH must be a power of two");
    end

    shift_kind_e kind;
    shift_ctl_t  ctl;
    logic [WIDTH-1:0] in_mirrored, tree_in, tree_out, out_mirrored;
    logic             fill_bit;

    shift_decode u_dec (
        .enable       (enable),
        .use_opcode   (use_opcode),
        .opcode       (opcode),
        .dir_left     (dir_left),
        .fill_logical (fill_logical),
        .kind         (kind),
        .ctl          (ctl)
    );

    bit_mirror #(.W(WIDTH)) u_pre  (.din(data_in),  .dout(in_mirrored));

    assign tree_in  = ctl.mirror ? in_mirrored : data_in;
    assign fill_bit = ctl.sign_fill & data_in[WIDTH-1];

    shift_tree #(.W(WIDTH), .AW(AMT_W)) u_tree (
        .din  (tree_in),
        .amt  (amount),
        .fill (fill_bit),
        .dout (tree_out)
    );

    bit_mirror #(.W(WIDTH)) u_post (.din(tree_out), .dout(out_mirrored));

    always_comb begin
        if (!ctl.active)     data_out = '0;
        else if (ctl.mirror) data_out = out_mirrored;
        else                 data_out = tree_out;
    end

    always_comb begin
        if (!enable)
            p_off_gives_zero_r5: assert (data_out == '0)
                else $error("output nonzero while disabled");
        if (enable && kind != SH_NONE && amount == '0)
            p_zero_amount_identity_r4: assert (data_out == data_in)
                else $error("zero distance changed the word");
        if (kind == SH_RIGHT_ARI)
            p_sign_kept_r3: assert (data_out[WIDTH-1] == data_in[WIDTH-1])
                else $error("arithmetic shift lost the sign");
        if (kind == SH_LEFT && amount != '0)
            p_left_low_zero_r1: assert (data_out[0] == 1'b0)
                else $error("left shift left a nonzero low bit");
        if (kind == SH_RIGHT_LOG && amount != '0)
            p_logic_top_zero_r2: assert (data_out[WIDTH-1] == 1'b0)
                else $error("logical right shift left a nonzero top bit");
    end

endmodule

// File: tb/log_shifter_test.sv
module log_shifter_test;

    logic clk = 1'b0;
    always #5 clk = ~clk;   // 100 MHz

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    // 32-bit instance
    logic        en = 1'b0, uop = 1'b0, dl = 1'b0, fl = 1'b0;
    logic [2:0]  opc = 3'd0;
    logic [4:0]  amt = 5'd0;
    logic [31:0] din = 32'd0, dout;

    log_shifter #(.WIDTH(32)) uut (
        .enable(en), .use_opcode(uop), .opcode(opc), .dir_left(dl),
        .fill_logical(fl), .amount(amt), .data_in(din), .data_out(dout)
    );

    // 8-bit instance for exhaustive sweep
    logic        s_en = 1'b0, s_dl = 1'b0, s_fl = 1'b0;
    logic [2:0]  s_amt = 3'd0;
    logic [7:0]  s_din = 8'd0, s_dout;

    log_shifter #(.WIDTH(8)) uut_small (
        .enable(s_en), .use_opcode(1'b0), .opcode(3'd0), .dir_left(s_dl),
        .fill_logical(s_fl), .amount(s_amt), .data_in(s_din), .data_out(s_dout)
    );

    // 0 none, 1 left, 2 logical right, 3 arithmetic right
    function automatic int kind_of(logic e, logic u, logic [2:0] o, logic d, logic f);
        if (!e) return 0;
        if (u) return (o == 3'b100) ? 1 : (o == 3'b101) ? 3 : 0;
        if (d) return 1;
        return f ? 2 : 3;
    endfunction

    function automatic logic [31:0] exp32(int k, logic [31:0] d, int n);
        case (k)
            1: return d << n;
            2: return d >> n;
            3: return $unsigned($signed(d) >>> n);
            default: return 32'd0;
        endcase
    endfunction

    function automatic logic [7:0] exp8(int k, logic [7:0] d, int n);
        case (k)
            1: return d << n;
            2: return d >> n;
            3: return $unsigned($signed(d) >>> n);
            default: return 8'd0;
        endcase
    endfunction

    function automatic string tag_of(logic e, logic u, int k, int n, logic d, logic f);
        if (!e) return "R5";
        if (u) return "R6";
        if (k != 0 && n == 0) return "R4";
        if (d && !f) return "R7";
        if (k == 1) return "R1";
        if (k == 2) return "R2";
        return "R3";
    endfunction

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic drive32(logic e, logic u, logic [2:0] o, logic d, logic f,
                           int n, logic [31:0] w);
        int k;
        en = e; uop = u; opc = o; dl = d; fl = f; amt = n[4:0]; din = w;
        @(negedge clk);   // combinational: due in the same cycle
        k = kind_of(e, u, o, d, f);
        check(tag_of(e, u, k, n, d, f), dout, exp32(k, w, n));
    endtask

    initial begin
        logic [31:0] words [3];
        @(negedge clk);
        // R5: idle state with enable low
        check("R5", dout, 32'd0);
        check("R5", {24'd0, s_dout}, 32'd0);
        drive32(1'b0, 1'b0, 3'd0, 1'b1, 1'b1, 3, 32'hFFFF_FFFF);
        drive32(1'b0, 1'b1, 3'b100, 1'b0, 1'b0, 7, 32'h8000_0001);

        // R8: distance 5 enables the 1- and 4-position stages
        drive32(1'b1, 1'b0, 3'd0, 1'b1, 1'b1, 5, 32'h0000_0001);
        check("R8", dout, 32'h0000_0020);

        // R1 R2 R3 R4 R6 R7: every distance and control combination
        for (int n = 0; n < 32; n++) begin
            words[0] = $urandom;
            words[1] = 32'h8000_0001;
            words[2] = 32'h7FFF_FFFF;
            for (int c = 0; c < 16; c++) begin
                for (int w = 0; w < 3; w++) begin
                    drive32(1'b1, c[3], c[2:0], c[1], c[0], n, words[w]);
                end
            end
        end

        // R7: exhaustive 8-bit sweep through the pin interface
        s_en = 1'b1;
        for (int m = 0; m < 3; m++) begin
            for (int n = 0; n < 8; n++) begin
                for (int d = 0; d < 256; d++) begin
                    s_dl = (m == 0); s_fl = (m == 1);
                    s_amt = n[2:0]; s_din = d[7:0];
                    @(negedge clk);
                    check(m == 0 ? "R1" : m == 1 ? "R2" : "R3", {24'd0, s_dout},
                          {24'd0, exp8(m + 1, d[7:0], n)});
                end
            end
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog got=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule